// File: doc/BRIEF.md
# Elementary Stream Resync Header Parser

This block sits between a video channel buffer and the decoding engine. It accepts a byte-wide elementary stream over a valid/ready handshake. It starts in a hunting state after reset, or whenever the resync input is raised, for example after a program change. While hunting it throws bytes away until it sees a sequence start code. During that search it raises a one-cycle interrupt pulse for every picture start code it skips.

Once the stream is in sync, the parser walks the header layers and copies every header byte it accepts to the write port of an auxiliary data FIFO. It tracks the current layer as each start code is classified. It stops in front of the picture payload, and it holds its input ready low until the decode-start command has been given. The command may be given before or during the stall. After that the parser forwards the payload bytes to the decoding engine on a separate byte stream.

Top module: `es_resync_parser`

## Requirements
- R1: After reset or resync, no accepted byte reaches the auxiliary port or the payload port until a complete start code with code byte 0xB3 is accepted. The state then becomes HEADER on the following clock edge.
- R2: While in HUNT, each accepted start code with code byte 0x00 produces `pic_irq` high for exactly one cycle, on the cycle after the code byte is accepted. No pulse is produced in any other state.
- R3: No auxiliary write occurs for bytes accepted in HUNT. Every byte accepted in HEADER, including the prefix and code bytes, appears on `aux_wr_data` with `aux_wr_en` high on the cycle after it is accepted.
- R4: A start-code prefix is two or more consecutive 0x00 bytes followed by 0x01. The next accepted byte is the code byte. A single 0x00 followed by 0x01 is not a prefix.
- R5: `layer_o` reports the most recent header layer: 0 none, 1 sequence (0xB3), 2 sequence extension (0xB5 after sequence), 3 group of pictures (0xB8), 4 user data (0xB2), 5 picture (0x00), 6 picture extension (0xB5 after picture). It returns to 0 on reset or resync.
- R6: In HEADER, a code byte from 0x01 to 0xAF (payload boundary) that arrives after a picture header moves the state to WAIT_START on the next edge. In that state `in_ready` is low and no byte is consumed.
- R7: WAIT_START moves to DECODE on the edge where `decode_start` is high, or on the first edge in WAIT_START if the command was given earlier since the last resync. In DECODE every accepted byte appears on `pay_data` with `pay_valid` high one cycle later.
- R8: `resync` high at a clock edge forces HUNT from any state, clears a pending decode-start command, and discards any byte accepted in that cycle.
- R9: `state_o` encodes HUNT=0, HEADER=1, WAIT_START=2, DECODE=3. Reset gives HUNT, `in_ready` high and all output strobes low.
- R10: In HEADER, a payload-range code byte that arrives before any picture header is ignored, and the parser stays in HEADER.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resync | input | 1 | Return to hunting from any state |
| decode_start | input | 1 | Decode-start command pulse |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input stream byte |
| in_ready | output | 1 | Parser can take a byte |
| aux_wr_en | output | 1 | Auxiliary FIFO write strobe |
| aux_wr_data | output | 8 | Auxiliary FIFO write byte |
| pay_valid | output | 1 | Payload byte strobe |
| pay_data | output | 8 | Payload byte |
| pic_irq | output | 1 | Skipped-picture pulse while hunting |
| state_o | output | 2 | Parser state |
| layer_o | output | 3 | Current header layer |

## Verification
The bench sends runs of three zeros before 0x01, and a lone zero before 0x01. A detector that counted the zeros wrongly would then miss a real code or accept a false one. It sends picture codes both during the hunt and after sync. A misplaced interrupt pulse shows up in the HEADER phase, and a missing one during the hunt. It sends a slice-range code before the picture header, where a premature stall would freeze the input. It issues the decode-start command both before the stall and during it, so a parser that forgot an early command would stay in WAIT_START forever. A resync in the middle of the header phase checks that auxiliary writes stop at once and that the layer indicator is cleared.

// File: rtl/es_pkg.sv
package es_pkg;

   typedef enum logic [1:0] {
      ST_HUNT   = 2'd0,
      ST_HEADER = 2'd1,
      ST_WAIT   = 2'd2,
      ST_DECODE = 2'd3
   } pst_e;

   typedef enum logic [2:0] {
      LY_NONE    = 3'd0,
      LY_SEQ     = 3'd1,
      LY_SEQ_EXT = 3'd2,
      LY_GOP     = 3'd3,
      LY_USER    = 3'd4,
      LY_PIC     = 3'd5,
      LY_PIC_EXT = 3'd6
   } layer_e;

   typedef enum logic [2:0] {
      CK_OTHER = 3'd0,
      CK_SEQ   = 3'd1,
      CK_PIC   = 3'd2,
      CK_GOP   = 3'd3,
      CK_USER  = 3'd4,
      CK_EXT   = 3'd5,
      CK_SLICE = 3'd6
   } kind_e;

   localparam logic [7:0] CODE_SEQ      = 8'hB3;
   localparam logic [7:0] CODE_PIC      = 8'h00;
   localparam logic [7:0] CODE_GOP      = 8'hB8;
   localparam logic [7:0] CODE_USER     = 8'hB2;
   localparam logic [7:0] CODE_EXT      = 8'hB5;
   localparam logic [7:0] CODE_SLICE_LO = 8'h01;
   localparam logic [7:0] CODE_SLICE_HI = 8'hAF;

   function automatic kind_e classify(input logic [7:0] code);
      kind_e k;
      if (code == CODE_SEQ)       k = CK_SEQ;
      else if (code == CODE_PIC)  k = CK_PIC;
      else if (code == CODE_GOP)  k = CK_GOP;
      else if (code == CODE_USER) k = CK_USER;
      else if (code == CODE_EXT)  k = CK_EXT;
      else if (code >= CODE_SLICE_LO && code <= CODE_SLICE_HI) k = CK_SLICE;
      else k = CK_OTHER;
      return k;
   endfunction

endpackage

// File: rtl/es_sc_detect.sv
module es_sc_detect #(
   parameter int DATA_W    = 8,
   parameter int MIN_ZEROS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              fire,
   input  logic [DATA_W-1:0] din,
   output logic              code_hit
);
   localparam int ZC_W = $clog2(MIN_ZEROS + 1);
   localparam logic [ZC_W-1:0] ZC_MAX = ZC_W'(MIN_ZEROS);

   if (MIN_ZEROS < 2) begin : g_bad_zeros
      $error("es_sc_detect: MIN_ZEROS must be at least 2");
   end
   if (DATA_W != 8) begin : g_bad_width
      $error("es_sc_detect: DATA_W must be 8");
   end

   logic [ZC_W-1:0] zcnt_q;
   logic            pfx_q;
   logic            is_zero;
   logic            is_one;

   assign is_zero  = (din == '0);
   assign is_one   = (din == DATA_W'(1));
   assign code_hit = fire && pfx_q && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zcnt_q <= '0;
         pfx_q  <= 1'b0;
      end else if (clr) begin
         zcnt_q <= '0;
         pfx_q  <= 1'b0;
      end else if (fire) begin
         if (pfx_q) begin
            pfx_q  <= 1'b0;
            zcnt_q <= '0;
         end else if (is_zero) begin
            if (zcnt_q != ZC_MAX) zcnt_q <= zcnt_q + 1'b1;
         end else if (is_one && zcnt_q == ZC_MAX) begin
            pfx_q  <= 1'b1;
            zcnt_q <= '0;
         end else begin
            zcnt_q <= '0;
         end
      end
   end
endmodule

// File: rtl/es_layer_track.sv
module es_layer_track
   import es_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   clr,
   input  logic   upd,
   input  kind_e  kind,
   output layer_e layer,
   output logic   pic_seen
);
   layer_e layer_q;
   layer_e layer_d;

   always_comb begin
      layer_d = layer_q;
      if (upd) begin
         case (kind)
            CK_SEQ:  layer_d = LY_SEQ;
            CK_GOP:  layer_d = LY_GOP;
            CK_USER: layer_d = LY_USER;
            CK_PIC:  layer_d = LY_PIC;
            CK_EXT: begin
               if (layer_q == LY_SEQ)      layer_d = LY_SEQ_EXT;
               else if (layer_q == LY_PIC) layer_d = LY_PIC_EXT;
            end
            default: layer_d = layer_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   layer_q <= LY_NONE;
      else if (clr) layer_q <= LY_NONE;
      else          layer_q <= layer_d;
   end

   assign layer    = layer_q;
   assign pic_seen = (layer_q == LY_PIC) || (layer_q == LY_PIC_EXT);
endmodule

// File: rtl/es_out_stage.sv
module es_out_stage #(
   parameter int W       = 9,
   parameter bit OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("es_out_stage: W must be positive");
   end

   if (OUT_REG) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_r <= '0;
         else        q_r <= d;
      end
      assign q = q_r;
   end else begin : g_wire
      assign q = d;
   end
endmodule

// File: rtl/es_resync_parser.sv
module es_resync_parser
   import es_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int MIN_ZEROS = 2,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              resync,
   input  logic              decode_start,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              aux_wr_en,
   output logic [DATA_W-1:0] aux_wr_data,
   output logic              pay_valid,
   output logic [DATA_W-1:0] pay_data,
   output logic              pic_irq,
   output logic [1:0]        state_o,
   output logic [2:0]        layer_o
);
   localparam int BUS_W = DATA_W + 1;

   if (DATA_W != 8) begin : g_bad_width
      $error("es_resync_parser: start codes are defined on 8-bit bytes");
   end

   pst_e   state_q, state_d;
   logic   pend_q, pend_d;
   logic   fire, keep;
   logic   code_hit;
   kind_e  kind;
   layer_e layer;
   logic   pic_seen;
   logic   layer_upd;
   logic   boundary;

   assign in_ready = (state_q != ST_WAIT);
   assign fire     = in_valid && in_ready;
   assign keep     = fire && !resync;
   assign kind     = classify(in_data);

   es_sc_detect #(.DATA_W(DATA_W), .MIN_ZEROS(MIN_ZEROS)) u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (resync),
      .fire     (fire),
      .din      (in_data),
      .code_hit (code_hit)
   );

   assign layer_upd = code_hit &&
                      ((state_q == ST_HEADER) ||
                       (state_q == ST_HUNT && kind == CK_SEQ));

   es_layer_track u_layer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (resync),
      .upd      (layer_upd),
      .kind     (kind),
      .layer    (layer),
      .pic_seen (pic_seen)
   );

   assign boundary = code_hit && (state_q == ST_HEADER) &&
                     (kind == CK_SLICE) && pic_seen;

   always_comb begin
      state_d = state_q;
      if (resync) begin
         state_d = ST_HUNT;
      end else begin
         case (state_q)
            ST_HUNT:   if (code_hit && kind == CK_SEQ) state_d = ST_HEADER;
            ST_HEADER: if (boundary) state_d = ST_WAIT;
            ST_WAIT:   if (pend_q || decode_start) state_d = ST_DECODE;
            default:   state_d = state_q;
         endcase
      end
   end

   always_comb begin
      if (resync)
         pend_d = 1'b0;
      else if (state_q == ST_DECODE || (state_q == ST_WAIT && (pend_q || decode_start)))
         pend_d = 1'b0;
      else
         pend_d = pend_q || decode_start;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HUNT;
         pend_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         pend_q  <= pend_d;
      end
   end

   logic [BUS_W-1:0] aux_d, aux_q, pay_d, pay_q;
   logic [0:0]       irq_d, irq_q;

   assign aux_d    = {keep && (state_q == ST_HEADER), in_data};
   assign pay_d    = {keep && (state_q == ST_DECODE), in_data};
   assign irq_d[0] = code_hit && (state_q == ST_HUNT) && (kind == CK_PIC);

   es_out_stage #(.W(BUS_W), .OUT_REG(OUT_REG)) u_aux_out (
      .clk (clk), .rst_n (rst_n), .d (aux_d), .q (aux_q)
   );
   es_out_stage #(.W(BUS_W), .OUT_REG(OUT_REG)) u_pay_out (
      .clk (clk), .rst_n (rst_n), .d (pay_d), .q (pay_q)
   );
   es_out_stage #(.W(1), .OUT_REG(OUT_REG)) u_irq_out (
      .clk (clk), .rst_n (rst_n), .d (irq_d), .q (irq_q)
   );

   assign aux_wr_en   = aux_q[DATA_W];
   assign aux_wr_data = aux_q[DATA_W-1:0];
   assign pay_valid   = pay_q[DATA_W];
   assign pay_data    = pay_q[DATA_W-1:0];
   assign pic_irq     = irq_q[0];
   assign state_o     = state_q;
   assign layer_o     = layer;
endmodule

// File: rtl/es_resync_parser_chk.sv
module es_resync_parser_chk #(
   parameter bit OUT_REG = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       resync,
   input logic       in_ready,
   input logic       aux_wr_en,
   input logic       pay_valid,
   input logic       pic_irq,
   input logic [1:0] state_o
);
   localparam logic [1:0] S_HUNT   = 2'd0;
   localparam logic [1:0] S_HEADER = 2'd1;
   localparam logic [1:0] S_WAIT   = 2'd2;
   localparam logic [1:0] S_DECODE = 2'd3;

   AST_RESYNC_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
      resync |=> state_o == S_HUNT);                                      // R8

   AST_HEADER_FROM_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == S_HEADER && $past(state_o) != S_HEADER) |-> $past(state_o) == S_HUNT); // R1

   AST_DECODE_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == S_DECODE && $past(state_o) != S_DECODE) |-> $past(state_o) == S_WAIT); // R7

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pic_irq |=> !pic_irq);                                              // R2

   AST_WAIT_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == S_WAIT && $past(state_o) == S_WAIT) |-> !in_ready);     // R6

   if (OUT_REG) begin : g_reg_chk
      AST_AUX_ONLY_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
         aux_wr_en |-> $past(state_o) == S_HEADER);                       // R3
      AST_IRQ_ONLY_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
         pic_irq |-> $past(state_o) == S_HUNT);                           // R2
      AST_WAIT_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
         state_o == S_WAIT |=> (!pay_valid && !aux_wr_en));               // R6
   end else begin : g_comb_chk
      AST_AUX_ONLY_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
         aux_wr_en |-> state_o == S_HEADER);                              // R3
      AST_IRQ_ONLY_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
         pic_irq |-> state_o == S_HUNT);                                  // R2
      AST_WAIT_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
         state_o == S_WAIT |-> (!pay_valid && !aux_wr_en));               // R6
   end
endmodule

bind es_resync_parser es_resync_parser_chk #(.OUT_REG(OUT_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .resync    (resync),
   .in_ready  (in_ready),
   .aux_wr_en (aux_wr_en),
   .pay_valid (pay_valid),
   .pic_irq   (pic_irq),
   .state_o   (state_o)
);

// File: tb/es_resync_parser_tb.sv
`timescale 1ns/1ps
module es_resync_parser_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       resync = 1'b0;
   logic       decode_start = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_ready, aux_wr_en, pay_valid, pic_irq;
   logic [7:0] aux_wr_data, pay_data;
   logic [1:0] state_o;
   logic [2:0] layer_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   es_resync_parser u_dut (
      .clk (clk), .rst_n (rst_n), .resync (resync), .decode_start (decode_start),
      .in_valid (in_valid), .in_data (in_data), .in_ready (in_ready),
      .aux_wr_en (aux_wr_en), .aux_wr_data (aux_wr_data),
      .pay_valid (pay_valid), .pay_data (pay_data), .pic_irq (pic_irq),
      .state_o (state_o), .layer_o (layer_o)
   );

   // behavioural reference model
   int m_st = 0, m_layer = 0, m_zeros = 0;
   bit m_pfx = 0, m_pend = 0, last_fire = 0;
   bit e_aux = 0, e_pay = 0, e_irq = 0;
   int e_auxd = 0, e_payd = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_layer = 0; m_zeros = 0; m_pfx = 0; m_pend = 0;
         e_aux = 0; e_pay = 0; e_irq = 0; last_fire = 0;
      end else begin
         bit fire, ok, hit;
         int b, old_st;
         bit new_pend;
         b = in_data;
         old_st = m_st;
         fire = in_valid && (m_st != 2);
         last_fire = fire;
         ok = fire && !resync;
         hit = ok && m_pfx;
         e_aux = ok && m_st == 1; e_auxd = b;
         e_pay = ok && m_st == 3; e_payd = b;
         e_irq = hit && m_st == 0 && b == 0;
         if (resync) new_pend = 0;
         else if (old_st == 3 || (old_st == 2 && (m_pend || decode_start))) new_pend = 0;
         else new_pend = m_pend || decode_start;
         if (resync) begin
            m_st = 0; m_layer = 0; m_zeros = 0; m_pfx = 0;
         end else begin
            if (hit) begin
               if (m_st == 0) begin
                  if (b == 8'hB3) begin m_st = 1; m_layer = 1; end
               end else if (m_st == 1) begin
                  if (b == 8'hB3) m_layer = 1;
                  else if (b == 8'hB8) m_layer = 3;
                  else if (b == 8'hB2) m_layer = 4;
                  else if (b == 8'h00) m_layer = 5;
                  else if (b == 8'hB5) begin
                     if (m_layer == 1) m_layer = 2;
                     else if (m_layer == 5) m_layer = 6;
                  end else if (b >= 1 && b <= 8'hAF && m_layer >= 5) m_st = 2;
               end
            end else if (old_st == 2 && (m_pend || decode_start)) begin
               m_st = 3;
            end
            if (ok) begin
               if (m_pfx) begin m_pfx = 0; m_zeros = 0; end
               else if (b == 0) m_zeros++;
               else if (b == 1 && m_zeros >= 2) begin m_pfx = 1; m_zeros = 0; end
               else m_zeros = 0;
            end
         end
         m_pend = new_pend;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(state_o == m_st, "R9 state", state_o, m_st);
         chk(in_ready == (m_st != 2), "R6 in_ready", in_ready, m_st != 2);
         chk(layer_o == m_layer, "R5 layer", layer_o, m_layer);
         chk(pic_irq == e_irq, "R2 pic_irq", pic_irq, e_irq);
         chk(aux_wr_en == e_aux, "R3 aux_wr_en", aux_wr_en, e_aux);
         if (e_aux) chk(aux_wr_data == e_auxd, "R3 aux_wr_data", aux_wr_data, e_auxd);
         chk(pay_valid == e_pay, "R7 pay_valid", pay_valid, e_pay);
         if (e_pay) chk(pay_data == e_payd, "R7 pay_data", pay_data, e_payd);
      end
   end

   task automatic put(input logic [7:0] b);
      in_valid = 1'b1;
      in_data  = b;
      do @(negedge clk); while (!last_fire);
      in_valid = 1'b0;
   endtask

   task automatic sc(input logic [7:0] code);
      put(8'h00); put(8'h00); put(8'h01); put(code);
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_resync();
      resync = 1'b1;
      @(negedge clk);
      resync = 1'b0;
   endtask

   int irq_cnt = 0;
   always @(negedge clk) if (rst_n && pic_irq) irq_cnt++;

   initial begin
      int wd = 0;
      while (!done) begin
         @(posedge clk);
         wd++;
         if (wd > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(state_o == 2'd0 && in_ready && !aux_wr_en && !pay_valid && !pic_irq,
          "R9 reset", state_o, 0);

      // hunting: picture codes skipped, junk dropped, short prefix ignored
      put(8'h47); put(8'hB3); sc(8'h00);
      put(8'h11); put(8'h00); put(8'h00); put(8'h00); put(8'h01); put(8'h00); // three zeros, R4
      put(8'h00); put(8'h01); put(8'hB3);                                   // one zero, R4
      idle(2);
      chk(irq_cnt == 2, "R2 skipped picture count", irq_cnt, 2);
      chk(state_o == 2'd0, "R4 lone zero prefix rejected", state_o, 0);

      // sync
      sc(8'hB3);
      chk(state_o == 2'd1, "R1 sequence code found", state_o, 1);
      put(8'h12); put(8'h34);
      sc(8'hB5); put(8'h5A);
      chk(layer_o == 3'd2, "R5 sequence extension", layer_o, 2);
      sc(8'hB8); put(8'h08);
      sc(8'hB2); put(8'hC3);
      sc(8'h07);
      chk(state_o == 2'd1, "R10 early slice ignored", state_o, 1);
      sc(8'h00); put(8'h3F);
      idle(1);
      chk(irq_cnt == 2, "R2 no pulse after sync", irq_cnt, 2);
      sc(8'hB5); put(8'h81);
      chk(layer_o == 3'd6, "R5 picture extension", layer_o, 6);
      sc(8'h01);
      chk(state_o == 2'd2, "R6 stalled at boundary", state_o, 2);

      // byte offered while stalled is held
      in_valid = 1'b1; in_data = 8'h77;
      repeat (4) @(negedge clk);
      chk(!in_ready, "R6 ready low while waiting", in_ready, 0);
      decode_start = 1'b1;
      @(negedge clk);
      decode_start = 1'b0;
      chk(state_o == 2'd3, "R7 decode entered on command", state_o, 3);
      @(negedge clk);
      in_valid = 1'b0;
      put(8'hAA); put(8'hBB); put(8'h00); put(8'h00); put(8'h01); put(8'hB3);
      idle(1);
      chk(state_o == 2'd3, "R7 stays decoding", state_o, 3);

      // resync from decode, early command
      pulse_resync();
      chk(state_o == 2'd0 && layer_o == 3'd0, "R8 resync from decode", state_o, 0);
      sc(8'h00);
      sc(8'hB3); put(8'h01);
      decode_start = 1'b1; @(negedge clk); decode_start = 1'b0;
      sc(8'h00); put(8'h22);
      sc(8'hAF);
      chk(state_o == 2'd2, "R6 boundary at top slice code", state_o, 2);
      @(negedge clk);
      chk(state_o == 2'd3, "R7 pending command honoured", state_o, 3);
      put(8'h5C);

      // resync in header drops in-flight byte
      pulse_resync();
      sc(8'hB3); put(8'h44);
      in_valid = 1'b1; in_data = 8'h99; resync = 1'b1;
      @(negedge clk);
      resync = 1'b0; in_valid = 1'b0;
      chk(state_o == 2'd0 && !aux_wr_en, "R8 resync drops header byte", state_o, 0);
      put(8'h55); put(8'h66);
      idle(3);
      chk(!aux_wr_en && !pay_valid, "R1 no output while hunting", aux_wr_en, 0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule